// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Serial Data Converter

This block sits between a two-wire serial bus and the control and result logic of a data converter. It runs on a fast system clock and oversamples the bus clock (SCL) and data (SDA) lines through two-flop synchronisers. From the synchronised lines it finds START, repeated START and STOP conditions, collects the address byte and compares it with a fixed 7-bit address. Write cycles deliver control bytes, and each byte is sorted by its top bit into one of two registers. Read cycles send out a result byte taken from an input port. The block drives SDA only as an open-drain pull-down enable.

A first byte of the form 00001xxx is taken as the high-speed master code. The block leaves it unacknowledged and raises a sticky high-speed flag. The flag survives repeated STARTs and only a STOP or reset clears it. The flag is reported to the rest of the converter; the bus timing itself does not change here.

The controller has nine states: IDLE (waiting for START), ADDR (shifting in the address byte), ADDR_ACK (pulling SDA low in the ninth clock), WR_BYTE (shifting in a data byte), WR_ACK (acknowledging it), RD_BYTE (shifting out the result), RD_ACK (sampling the master's answer), HS_NACK (letting the ninth clock of the master code pass unacknowledged) and IGNORE (address mismatch). The transitions are as follows:
- Any state goes to ADDR on START and to IDLE on STOP.
- ADDR goes to HS_NACK, ADDR_ACK or IGNORE at the falling SCL edge that ends bit 8.
- ADDR_ACK goes to WR_BYTE or RD_BYTE, depending on the R/W bit, at the falling edge that ends the ninth clock.
- WR_BYTE goes to WR_ACK, and WR_ACK goes back to WR_BYTE.
- RD_BYTE goes to RD_ACK. RD_ACK goes back to RD_BYTE on an acknowledge and to IDLE on a not-acknowledge.
- HS_NACK goes to IDLE and keeps waiting for the repeated START.

Top module: `conv_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen on the synchronised lines. Either condition abandons any byte in progress: a partial data byte changes no register, and after a START a fresh address byte is collected.
- R2: The slave address is 1100101 when parameter ADDR_OPTION is 1 (the default) and 1100100 when it is 0. The address byte carries the address in bits 7..1 and R/W in bit 0, where 0 means write and 1 means read. On a match the slave pulls SDA low through the high phase of the ninth clock.
- R3: On an address mismatch SDA stays released for the rest of the transfer, no register changes and no strobe fires until the next START.
- R4: A first byte whose upper five bits are 00001 is the high-speed master code. SDA stays released in its ninth clock, and hs_mode is 1 after that clock ends.
- R5: hs_mode stays 1 across repeated STARTs and the transfers that follow them. A STOP clears it.
- R6: In a write cycle, a data byte with bit 7 = 1 is stored in setup_q and a byte with bit 7 = 0 is stored in config_q. Each store raises its strobe (setup_stb or config_stb) for exactly one clock, the two strobes never fire together, and every data byte is acknowledged.
- R7: A write cycle may carry bytes in any order and any number. A later byte of the same class overwrites the earlier value.
- R8: In a read cycle the byte present on result_i at the end of the address acknowledge is sent MSB first. The slave changes SDA only while SCL is low.
- R9: After a master acknowledge the slave sends the value of result_i sampled at the end of that acknowledge clock. After a not-acknowledge it releases SDA and waits for the next START.
- R10: After reset sda_oe, setup_q, config_q, hs_mode and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| result_i | input | 8 | Conversion result to be read out |
| setup_q | output | 8 | Last written byte with bit 7 = 1 |
| config_q | output | 8 | Last written byte with bit 7 = 0 |
| setup_stb | output | 1 | One-clock pulse when setup_q is loaded |
| config_stb | output | 1 | One-clock pulse when config_q is loaded |
| hs_mode | output | 1 | High-speed flag, set by the master code and cleared by STOP |

## Verification
The assertions assume a well-behaved master. It never moves SDA while SCL is high except to form START or STOP. It does not issue a START or STOP while the slave is pulling SDA low. Each SCL phase lasts longer than the synchroniser delay. Under those assumptions a change of the slave's SDA enable during a high SCL phase means a real fault. The bench master holds every quarter of a bit period for eight system clocks and changes its own SDA only with SCL low. It issues conditions only when the slave has released the line: after a completed acknowledge, or in the middle of a byte the master itself is writing.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;

    localparam int BYTE_W = 8;

    localparam logic [6:0] ADDR_BASE = 7'b1100100;
    localparam logic [6:0] ADDR_ALT  = 7'b1100101;
    localparam logic [4:0] HS_PREFIX = 5'b00001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HS_NACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Idle bus lines read high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s && !scl_d;
    assign scl_fall  = !scl_s &&  scl_d;
    // Conditions need SCL high on both samples around the SDA edge.
    assign start_det =  scl_s &&  scl_d &&  sda_d && !sda_s;
    assign stop_det  =  scl_s &&  scl_d && !sda_d &&  sda_s;

endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave
    import conv_i2c_pkg::*;
#(
    parameter bit ADDR_OPTION = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] result_i,
    output logic [BYTE_W-1:0] setup_q,
    output logic [BYTE_W-1:0] config_q,
    output logic              setup_stb,
    output logic              config_stb,
    output logic              hs_mode
);

    localparam logic [6:0] SLV_ADDR = ADDR_OPTION ? ADDR_ALT : ADDR_BASE;
    localparam int         CNT_W    = $clog2(BYTE_W + 1);

    logic [1:0]        line_s;
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;

    slv_state_e        state;
    slv_state_e        state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_bit;
    logic              mst_ack;
    logic              byte_end;
    logic              hs_code;
    logic              addr_hit;

    i2c_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_end = scl_fall && (bitcnt == CNT_W'(BYTE_W));
    assign hs_code  = (shreg[BYTE_W-1 -: 5] == HS_PREFIX);
    assign addr_hit = (shreg[BYTE_W-1:1] == SLV_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (byte_end) begin
                        if (hs_code)       state_nx = ST_HS_NACK;
                        else if (addr_hit) state_nx = ST_ADDR_ACK;
                        else               state_nx = ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) state_nx = rw_bit ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = mst_ack ? ST_RD_BYTE : ST_IDLE;
                ST_HS_NACK:  if (scl_fall) state_nx = ST_IDLE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Shifter, counter, captured registers and mode flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bitcnt     <= '0;
            rw_bit     <= 1'b0;
            mst_ack    <= 1'b0;
            setup_q    <= '0;
            config_q   <= '0;
            setup_stb  <= 1'b0;
            config_stb <= 1'b0;
            hs_mode    <= 1'b0;
        end else begin
            setup_stb  <= 1'b0;
            config_stb <= 1'b0;
            if (stop_det) begin
                bitcnt  <= '0;
                hs_mode <= 1'b0;
            end else if (start_det) begin
                bitcnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                rw_bit <= shreg[0];
                            end else if (shreg[BYTE_W-1]) begin
                                setup_q   <= shreg;
                                setup_stb <= 1'b1;
                            end else begin
                                config_q   <= shreg;
                                config_stb <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && rw_bit) shreg <= result_i;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                        end else if (scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)      mst_ack <= !sda_s;
                        else if (scl_fall) shreg   <= result_i;
                    end
                    ST_HS_NACK: begin
                        if (scl_fall) hs_mode <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = !shreg[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/conv_i2c_slave_chk.sv
module conv_i2c_slave_chk
    import conv_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              hs_mode,
    input logic              setup_stb,
    input logic              config_stb,
    input logic [BYTE_W-1:0] setup_q,
    input logic [BYTE_W-1:0] config_q
);

    // R8: the enable may only move while the synchronised SCL is low
    a_r8_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R1: a START leaves SDA released while the address is collected
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R5: STOP clears the high-speed flag
    a_r5_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R6: strobes are single pulses and never coincide
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_stb && config_stb));

    a_r6_setup_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> !setup_stb);

    a_r6_config_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        config_stb |=> !config_stb);

    // R6: the stored byte matches its class
    a_r6_setup_class: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |-> setup_q[BYTE_W-1]);

    a_r6_config_class: assert property (@(posedge clk) disable iff (!rst_n)
        config_stb |-> !config_q[BYTE_W-1]);

endmodule

bind conv_i2c_slave conv_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_oe     (sda_oe),
    .hs_mode    (hs_mode),
    .setup_stb  (setup_stb),
    .config_stb (config_stb),
    .setup_q    (setup_q),
    .config_q   (config_q)
);

// File: tb/sim_conv_i2c_slave.sv
`timescale 1ns/1ps
module sim_conv_i2c_slave;

    localparam int Q = 8;            // system clocks per quarter bit
    localparam logic [7:0] A_WR = 8'hCA; // 1100101 + write
    localparam logic [7:0] A_RD = 8'hCB; // 1100101 + read

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       m_oe = 1'b0;
    logic       sda_bus;
    logic       s_oe;
    logic [7:0] result;
    logic [7:0] setup_q;
    logic [7:0] config_q;
    logic       setup_stb;
    logic       config_stb;
    logic       hs_mode;

    int  n_chk = 0;
    int  n_err = 0;
    bit  mon_en = 1'b0;

    // reference model state
    logic [7:0] exp_setup = 8'h00;
    logic [7:0] exp_cfg   = 8'h00;
    bit         exp_hs    = 1'b0;
    int         exp_s_cnt = 0;
    int         exp_c_cnt = 0;
    int         seen_s    = 0;
    int         seen_c    = 0;
    bit         prev_s    = 1'b0;
    bit         prev_c    = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = !(m_oe || s_oe);

    conv_i2c_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (s_oe),
        .result_i   (result),
        .setup_q    (setup_q),
        .config_q   (config_q),
        .setup_stb  (setup_stb),
        .config_stb (config_stb),
        .hs_mode    (hs_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison with the model while the bus is quiet
    always @(negedge clk) begin
        if (rst_n) begin
            if (setup_stb) seen_s++;
            if (config_stb) seen_c++;
            if (setup_stb && prev_s) chk(1'b0, "R6 setup strobe width", 2, 1);
            if (config_stb && prev_c) chk(1'b0, "R6 config strobe width", 2, 1);
            prev_s = setup_stb;
            prev_c = config_stb;
        end
        if (mon_en) begin
            chk(setup_q == exp_setup, "R6 setup_q model", setup_q, exp_setup);
            chk(config_q == exp_cfg, "R6 config_q model", config_q, exp_cfg);
            chk(hs_mode == exp_hs, "R5 hs_mode model", hs_mode, exp_hs);
            chk(s_oe == 1'b0, "R9 idle release", s_oe, 0);
        end
    end

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        mon_en = 1'b0;
        m_oe = 1'b1; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_rstart();
        m_oe = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        m_oe = 1'b1; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_oe = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        m_oe = 1'b0; quarter();
        quarter();
        mon_en = 1'b1;
        quarter();
    endtask

    task automatic put_bit(input bit b);
        m_oe = !b; quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic get_bit(output bit b, output bit steady);
        m_oe = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        b = sda_bus; quarter();
        steady = (sda_bus == b);
        scl_m = 1'b0; quarter();
    endtask

    task automatic put_byte(input logic [7:0] d, output bit acked);
        bit r, s;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(r, s);
        acked = !r;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit give_ack, output bit steady);
        bit b, s;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, s);
            d[i] = b;
            steady = steady && s;
        end
        put_bit(!give_ack);
    endtask

    task automatic model_write(input logic [7:0] d);
        if (d[7]) begin exp_setup = d; exp_s_cnt++; end
        else      begin exp_cfg = d;   exp_c_cnt++; end
    endtask

    task automatic write_seq(input logic [7:0] d, input string tag);
        bit ak;
        put_byte(d, ak);
        chk(ak, tag, ak, 1);
        model_write(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit ak, st;
        logic [7:0] rd;
        result = 8'hA7;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(s_oe == 1'b0, "R10 sda_oe", s_oe, 0);
        chk(setup_q == 8'h00, "R10 setup_q", setup_q, 0);
        chk(config_q == 8'h00, "R10 config_q", config_q, 0);
        chk(hs_mode == 1'b0, "R10 hs_mode", hs_mode, 0);
        chk(!setup_stb && !config_stb, "R10 strobes", {setup_stb, config_stb}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        quarter(); quarter();

        // R2 + R6: single setup byte
        bus_start();
        put_byte(A_WR, ak);
        chk(ak, "R2 address ack", ak, 1);
        write_seq(8'h85, "R6 setup byte ack");
        bus_stop();

        // R7: configuration byte first, then setup
        bus_start();
        put_byte(A_WR, ak);
        chk(ak, "R2 address ack", ak, 1);
        write_seq(8'h1A, "R7 config first ack");
        write_seq(8'hC3, "R7 setup second ack");
        bus_stop();

        // R7: three bytes, last setup overwrites
        bus_start();
        put_byte(A_WR, ak);
        write_seq(8'h90, "R7 byte one ack");
        write_seq(8'h22, "R7 byte two ack");
        write_seq(8'hA5, "R7 byte three ack");
        bus_stop();
        chk(setup_q == 8'hA5, "R7 overwrite setup", setup_q, 8'hA5);
        chk(config_q == 8'h22, "R7 config kept", config_q, 8'h22);

        // R3: mismatched address
        bus_start();
        put_byte(8'hCC, ak);
        chk(!ak, "R3 no ack on mismatch", ak, 0);
        put_byte(8'h99, ak);
        chk(!ak, "R3 data ignored", ak, 0);
        bus_stop();
        chk(setup_q == 8'hA5, "R3 setup unchanged", setup_q, 8'hA5);

        // R4 + R5: high-speed master code
        bus_start();
        put_byte(8'h0D, ak);
        chk(!ak, "R4 master code not acked", ak, 0);
        chk(hs_mode == 1'b1, "R4 hs_mode set", hs_mode, 1);
        exp_hs = 1'b1;
        bus_rstart();
        put_byte(A_WR, ak);
        chk(ak, "R5 address ack after Sr", ak, 1);
        write_seq(8'h11, "R5 data ack in hs");
        chk(hs_mode == 1'b1, "R5 hs kept across Sr", hs_mode, 1);
        exp_hs = 1'b0;
        bus_stop();
        chk(hs_mode == 1'b0, "R5 stop clears hs", hs_mode, 0);

        // R8 + R9: read two bytes
        bus_start();
        put_byte(A_RD, ak);
        chk(ak, "R2 read address ack", ak, 1);
        result = 8'h3C;
        get_byte(rd, 1'b1, st);
        chk(rd == 8'hA7, "R8 first result byte", rd, 8'hA7);
        chk(st, "R8 SDA steady while SCL high", st, 1);
        result = 8'h5E;
        get_byte(rd, 1'b0, st);
        chk(rd == 8'h3C, "R9 next byte after ack", rd, 8'h3C);
        chk(st, "R8 SDA steady second byte", st, 1);
        chk(s_oe == 1'b0, "R9 released after nack", s_oe, 0);
        bus_stop();

        // R1: START aborts a partial address
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        bus_rstart();
        put_byte(A_WR, ak);
        chk(ak, "R1 address after restart", ak, 1);
        write_seq(8'h44, "R1 data after restart");
        bus_stop();

        // R1: STOP aborts a partial data byte
        bus_start();
        put_byte(A_WR, ak);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk(setup_q == 8'hA5 && config_q == 8'h44, "R1 partial byte dropped",
            {setup_q, config_q}, {8'hA5, 8'h44});

        // R6: strobe counts
        chk(seen_s == exp_s_cnt, "R6 setup strobe count", seen_s, exp_s_cnt);
        chk(seen_c == exp_c_cnt, "R6 config strobe count", seen_c, exp_c_cnt);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule